// File: doc/BRIEF.md
# Asynchronous Static RAM Behavioural Model

This block is a synthesizable, clock-sampled stand-in for a 16-bit-wide asynchronous static RAM whose controls are all active low. On every edge of a model clock it samples chip select, write strobe, output-enable strobe and two byte-lane enables. It decodes them into one of four operating modes, commits writes to the enabled byte lanes, and prepares read data for the next cycle. A system simulation or an FPGA prototype can use it wherever a real memory of that kind would sit on a board.

The bidirectional data bus is split into an input word, an output word and one drive-enable flag per byte lane. A pad wrapper or a test harness turns these into real tri-state lines. A lane that is not driven shows zero on the output word. The chip select can be built with one pin or as a pair of pins; the pair form selects the device only when the first pin is low and the second is high. The logical address is 18 bits wide. The storage depth is a parameter, and address bits above that depth are ignored.

Top module: `sram_model`

## Requirements
- R1: While `ce1_n` is high, the next registered outputs are `mode`=0 (deselect), `standby`=1, `drive_lo`=`drive_hi`=0 and `data_out`=0, whatever `we_n`, `oe_n`, `bhe_n` and `ble_n` are. A write strobe in that state leaves the memory unchanged.
- R2: With the two-pin select (`DUAL_CE`=1, the default), the device is selected only when `ce1_n`=0 and `ce2`=1. Every other combination of the two pins gives the deselect outputs of R1 and writes nothing.
- R3: When the device is selected but both `bhe_n` and `ble_n` are high, the device is deselected: `mode`=0, `standby`=1 and nothing is driven. A write strobe in that state changes no stored data.
- R4: When the device is selected, `we_n`=0 and at least one byte enable is low, the next `mode` is 2 (write) and both drive flags are 0, whatever `oe_n` is.
- R5: In write mode, bits 7:0 of `data_in` are stored when `ble_n`=0 and bits 15:8 when `bhe_n`=0, at the sampled address on that clock edge. A lane whose enable is high keeps its old contents.
- R6: When the device is selected with `we_n`=1, `oe_n`=0 and at least one byte enable low, the next `mode` is 1 (read). `drive_lo`=!`ble_n` and `drive_hi`=!`bhe_n`. Each driven lane of `data_out` holds the stored byte at the sampled address, and each undriven lane is 0.
- R7: When the device is selected with `we_n`=1, `oe_n`=1 and at least one byte enable low, the next `mode` is 3 (output disabled) with `standby`=0 and no lane driven.
- R8: Writes may happen on consecutive clock edges to different addresses. A read sampled on the edge directly after a write returns the newly written data.
- R9: Only the low `DEPTH_LOG2` address bits select a word. Addresses that differ only above that point reach the same word.
- R10: While `rst` is high, the registered outputs are `mode`=0, `standby`=1, both drive flags 0 and `data_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Second chip select, active high (two-pin option only) |
| addr | input | 18 | Word address |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| bhe_n | input | 1 | Upper byte lane enable, active low |
| ble_n | input | 1 | Lower byte lane enable, active low |
| data_in | input | 16 | Write data from the bus |
| data_out | output | 16 | Read data toward the bus, zero in undriven lanes |
| drive_lo | output | 1 | Bus drive enable for bits 7:0 |
| drive_hi | output | 1 | Bus drive enable for bits 15:8 |
| mode | output | 2 | Decoded mode: 0 deselect, 1 read, 2 write, 3 output disabled |
| standby | output | 1 | High while the device is deselected |

## Verification
Two functions meet on neighbouring clock edges: a lane write commits on one edge, and a read of the same word is sampled on the very next edge, so the memory write and the registered read path touch the same word back to back. The bench provokes this with an unbroken run of writes followed at once by a read of the last address. It also does this with a partial-lane write over a full word and an immediate read. It judges the result against its own word model, byte by byte, together with the lane drive flags.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  typedef enum logic [1:0] {
    MODE_DESEL  = 2'd0,
    MODE_READ   = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_OUTOFF = 2'd3
  } sram_mode_e;

  localparam int LANE_W = 8;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_model_pkg::*;
#(
  parameter int DUAL_CE = 1,
  parameter int LANES   = 2
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_en_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);

  logic selected;
  logic any_lane;

  generate
    if (DUAL_CE != 0) begin : g_two_pin
      assign selected = ~ce1_n & ce2;
    end else begin : g_one_pin
      logic unused_ce2;
      assign unused_ce2 = ce2;
      assign selected   = ~ce1_n;
    end
  endgenerate

  assign any_lane = ~(&lane_en_n);

  always_comb begin
    if (!selected || !any_lane) begin
      mode = MODE_DESEL;
    end else if (!we_n) begin
      mode = MODE_WRITE;
    end else if (!oe_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_OUTOFF;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_wr[i] = (mode == MODE_WRITE) && !lane_en_n[i];
      lane_rd[i] = (mode == MODE_READ)  && !lane_en_n[i];
    end
  end

endmodule

// File: rtl/sram_lane_ram.sv
module sram_lane_ram #(
  parameter int DEPTH_LOG2 = 10,
  parameter int WIDTH      = 8
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [DEPTH_LOG2-1:0] addr,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      rdata
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[addr] <= wdata;
    end
    rdata <= store[addr];
  end

endmodule

// File: rtl/sram_bus_stage.sv
module sram_bus_stage
  import sram_model_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sram_mode_e              mode_d,
  input  logic [LANES-1:0]        lane_rd,
  input  logic [LANES*LANE_W-1:0] ram_word,
  output sram_mode_e              mode_q,
  output logic                    standby_q,
  output logic [LANES-1:0]        drive_q,
  output logic [LANES*LANE_W-1:0] bus_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_DESEL;
      standby_q <= 1'b1;
      drive_q   <= '0;
    end else begin
      mode_q    <= mode_d;
      standby_q <= (mode_d == MODE_DESEL);
      drive_q   <= lane_rd;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_gate
      assign bus_word[g*LANE_W +: LANE_W] =
        drive_q[g] ? ram_word[g*LANE_W +: LANE_W] : '0;
    end
  endgenerate

endmodule

// File: rtl/sram_model.sv
module sram_model
  import sram_model_pkg::*;
#(
  parameter int DUAL_CE    = 1,
  parameter int ADDR_W     = 18,
  parameter int DEPTH_LOG2 = 10,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              bhe_n,
  input  logic              ble_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              drive_lo,
  output logic              drive_hi,
  output logic [1:0]        mode,
  output logic              standby
);

  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0]      lane_en_n;
  logic [LANES-1:0]      lane_wr;
  logic [LANES-1:0]      lane_rd;
  logic [LANES-1:0]      drive_q;
  logic [DATA_W-1:0]     ram_word;
  logic [DEPTH_LOG2-1:0] word_addr;
  logic                  unused_addr_hi;
  sram_mode_e            mode_d;
  sram_mode_e            mode_q;

  assign lane_en_n      = {bhe_n, ble_n};
  assign word_addr      = addr[DEPTH_LOG2-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:DEPTH_LOG2];

  sram_mode_decode #(
    .DUAL_CE (DUAL_CE),
    .LANES   (LANES)
  ) u_decode (
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .lane_en_n (lane_en_n),
    .mode      (mode_d),
    .lane_wr   (lane_wr),
    .lane_rd   (lane_rd)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane_ram #(
        .DEPTH_LOG2 (DEPTH_LOG2),
        .WIDTH      (LANE_W)
      ) u_ram (
        .clk   (clk),
        .wr_en (lane_wr[g]),
        .addr  (word_addr),
        .wdata (data_in[g*LANE_W +: LANE_W]),
        .rdata (ram_word[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  sram_bus_stage #(
    .LANES (LANES)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .mode_d    (mode_d),
    .lane_rd   (lane_rd),
    .ram_word  (ram_word),
    .mode_q    (mode_q),
    .standby_q (standby),
    .drive_q   (drive_q),
    .bus_word  (data_out)
  );

  assign mode     = mode_q;
  assign drive_lo = drive_q[0];
  assign drive_hi = drive_q[LANES-1];

endmodule

// File: rtl/sram_model_chk.sv
module sram_model_chk #(
  parameter int DUAL_CE = 1,
  parameter int DATA_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ce1_n,
  input logic              ce2,
  input logic              we_n,
  input logic              oe_n,
  input logic              bhe_n,
  input logic              ble_n,
  input logic [DATA_W-1:0] data_out,
  input logic              drive_lo,
  input logic              drive_hi,
  input logic [1:0]        mode,
  input logic              standby
);

  logic sel_c;
  assign sel_c = (DUAL_CE != 0) ? (!ce1_n && ce2) : !ce1_n;

  // R1
  ce_off_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    ce1_n |=> (mode == 2'd0 && standby && !drive_lo && !drive_hi));

  // R2
  ce2_low_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (DUAL_CE != 0 && !ce2) |=> (mode == 2'd0 && standby));

  // R3
  lanes_off_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (bhe_n && ble_n) |=> (mode == 2'd0 && !drive_lo && !drive_hi));

  // R4
  write_floats_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_c && !we_n && !(bhe_n && ble_n)) |=>
      (mode == 2'd2 && !drive_lo && !drive_hi && !standby));

  // R6
  read_lane_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_c && we_n && !oe_n && !(bhe_n && ble_n)) |=>
      (mode == 2'd1 && drive_lo == $past(!ble_n) && drive_hi == $past(!bhe_n)));

  // R6
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!drive_lo |-> data_out[7:0] == 8'h00) and (!drive_hi |-> data_out[15:8] == 8'h00));

  // R7
  outoff_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_c && we_n && oe_n && !(bhe_n && ble_n)) |=>
      (mode == 2'd3 && !standby && !drive_lo && !drive_hi));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mode == 2'd0 && standby && !drive_lo && !drive_hi));

endmodule

bind sram_model sram_model_chk #(.DUAL_CE(DUAL_CE), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sram_model.sv
`timescale 1ns/100ps
module sim_sram_model;

  localparam int DL = 6;
  localparam int DEPTH = 1 << DL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce1_n = 1'b1, ce2 = 1'b0;
  logic [17:0] addr = '0;
  logic        we_n = 1'b1, oe_n = 1'b1, bhe_n = 1'b1, ble_n = 1'b1;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        drive_lo, drive_hi, standby;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  sram_model #(.DUAL_CE(1), .DEPTH_LOG2(DL)) u0 (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .addr(addr),
    .we_n(we_n), .oe_n(oe_n), .bhe_n(bhe_n), .ble_n(ble_n),
    .data_in(data_in), .data_out(data_out), .drive_lo(drive_lo),
    .drive_hi(drive_hi), .mode(mode), .standby(standby)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c1, input logic c2, input logic w, input logic o,
                      input logic bh, input logic bl, input logic [17:0] a,
                      input logic [15:0] d);
    ce1_n = c1; ce2 = c2; we_n = w; oe_n = o; bhe_n = bh; ble_n = bl;
    addr = a; data_in = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d,
                    input logic bh, input logic bl);
    pins(1'b0, 1'b1, 1'b0, 1'b1, bh, bl, a, d);
    tick();
    if (!bl) ref_mem[a[DL-1:0]][7:0]  = d[7:0];
    if (!bh) ref_mem[a[DL-1:0]][15:8] = d[15:8];
  endtask

  task automatic rd_chk(input string req, input logic [17:0] a,
                        input logic bh, input logic bl);
    logic [15:0] exp;
    pins(1'b0, 1'b1, 1'b1, 1'b0, bh, bl, a, 16'h0);
    tick();
    exp = ref_mem[a[DL-1:0]];
    if (bl) exp[7:0]  = 8'h00;
    if (bh) exp[15:8] = 8'h00;
    chk({req, " mode"}, 32'(mode), 32'd1);
    chk({req, " data"}, 32'(data_out), 32'(exp));
    chk({req, " drive"}, {30'd0, drive_hi, drive_lo}, {30'd0, !bh, !bl});
  endtask

  task automatic desel_chk(input string req);
    chk({req, " mode"}, 32'(mode), 32'd0);
    chk({req, " standby"}, 32'(standby), 32'd1);
    chk({req, " drive"}, {30'd0, drive_hi, drive_lo}, 32'd0);
    chk({req, " data"}, 32'(data_out), 32'd0);
  endtask

  task automatic t_reset();
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'd0, 16'h0);
    tick(); tick();
    desel_chk("R10");
    rst = 1'b0;
  endtask

  task automatic t_ce_off();
    wr(18'd4, 16'hBEEF, 1'b0, 1'b0);
    pins(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd4, 16'h1111);
    tick();
    desel_chk("R1");
    rd_chk("R1 no write", 18'd4, 1'b0, 1'b0);
  endtask

  task automatic t_dual();
    pins(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'd4, 16'h2222);
    tick();
    desel_chk("R2 ce2 low");
    pins(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'd4, 16'h0);
    tick();
    desel_chk("R2 both off");
    rd_chk("R2 selected", 18'd4, 1'b0, 1'b0);
  endtask

  task automatic t_lanes_off();
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 18'd4, 16'h3333);
    tick();
    desel_chk("R3");
    rd_chk("R3 no write", 18'd4, 1'b0, 1'b0);
  endtask

  task automatic t_write();
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd9, 16'hA5C3);
    tick();
    ref_mem[9] = 16'hA5C3;
    chk("R4 mode oe low", 32'(mode), 32'd2);
    chk("R4 no drive", {30'd0, drive_hi, drive_lo}, 32'd0);
    chk("R4 standby", 32'(standby), 32'd0);
    wr(18'd10, 16'h0F0F, 1'b0, 1'b0);
    chk("R4 mode oe high", 32'(mode), 32'd2);
  endtask

  task automatic t_lane_mask();
    wr(18'd9, 16'h1234, 1'b1, 1'b0);
    rd_chk("R5 low lane", 18'd9, 1'b0, 1'b0);
    wr(18'd9, 16'h9876, 1'b0, 1'b1);
    rd_chk("R5 high lane", 18'd9, 1'b0, 1'b0);
  endtask

  task automatic t_read_lanes();
    rd_chk("R6 low only", 18'd10, 1'b1, 1'b0);
    rd_chk("R6 high only", 18'd9, 1'b0, 1'b1);
    rd_chk("R6 both", 18'd9, 1'b0, 1'b0);
  endtask

  task automatic t_outoff();
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'd9, 16'h0);
    tick();
    chk("R7 mode", 32'(mode), 32'd3);
    chk("R7 standby", 32'(standby), 32'd0);
    chk("R7 drive", {30'd0, drive_hi, drive_lo}, 32'd0);
    chk("R7 data", 32'(data_out), 32'd0);
  endtask

  task automatic t_b2b();
    for (int i = 0; i < 8; i++) begin
      wr(18'(20 + i), 16'(16'h4100 + i * 16'h0111), 1'b0, 1'b0);
    end
    rd_chk("R8 right after write", 18'd27, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) begin
      rd_chk("R8 burst", 18'(20 + i), 1'b0, 1'b0);
    end
  endtask

  task automatic t_alias();
    wr(18'd7 + 18'(5 * DEPTH), 16'hC0DE, 1'b0, 1'b0);
    rd_chk("R9 low alias", 18'd7, 1'b0, 1'b0);
    rd_chk("R9 high alias", 18'h3FFC7, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0;
    t_reset();
    t_ce_off();
    t_dual();
    t_lanes_off();
    t_write();
    t_lane_mask();
    t_read_lanes();
    t_outoff();
    t_b2b();
    t_alias();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule